// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block drives the active-low reset line of a host processor. The reset is held while an external supply comparator reports a low supply. After the supply comes back it stays held for a fixed stretch, which gives the supply and the oscillator time to settle. The stretch length is a parameter in clock cycles; its default equals 250 ms at 250 MHz.

The block also contains a watchdog. The host restarts it by pulling a shared chip-select line low, so each falling edge on that line counts as a restart. If no restart arrives within the selected interval, the supervisor asserts reset, runs the same stretch, and then releases reset again. A 2-bit configuration register selects one of three intervals or turns the watchdog off. Only an explicit configuration write changes this register. A supply loss does not clear it, which models a setting that survives a power cycle.

Top module: `reset_supervisor`

## Requirements
- R1: `rst_out_n` is 0 whenever `supply_ok` is 0, with no wait for a clock edge.
- R2: After `supply_ok` rises, `rst_out_n` stays 0 for exactly `STRETCH_CYC` rising clock edges. It goes to 1 on the last of those edges.
- R3: A 1-to-0 transition on `wd_kick_cs` restarts the watchdog. The line passes through a two-flop synchronizer, so a low level first sampled at edge A clears the count at edge A+2. Reset then falls at edge A+2+T, where T is the selected interval.
- R4: With no restart, `rst_out_n` falls on the T-th rising edge after the count was last cleared. This holds whether `wd_kick_cs` stays at 1 or stays at 0.
- R5: The select code sets T: code 00 gives `WD_CYC_SHORT`, code 01 gives `WD_CYC_MID`, and code 10 gives `WD_CYC_LONG`.
- R6: Select code 11 disables the watchdog. With code 11, only a low supply ever asserts reset.
- R7: A watchdog timeout holds `rst_out_n` at 0 for exactly `STRETCH_CYC` edges before it releases. The watchdog count stays cleared while reset is held, so a full interval starts again at release.
- R8: The select register loads `cfg_sel` only at a rising edge with `cfg_we` = 1. It ignores `cfg_sel` when `cfg_we` = 0, and it keeps its value through a supply loss.
- R9: When a restart and a timeout fall on the same edge, the restart wins and reset is not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| supply_ok | input | 1 | Comparator output: 1 when the supply is above trip, 0 when low (acts as an asynchronous reset) |
| wd_kick_cs | input | 1 | Shared chip-select line; each falling edge restarts the watchdog |
| cfg_we | input | 1 | Load strobe for the timeout select register |
| cfg_sel | input | 2 | Select code: 00 short, 01 mid, 10 long, 11 watchdog off |
| rst_out_n | output | 1 | Active-low reset to the host |

## Verification
The watchdog is driven with the kick line held high and then held low, which shows that only falling edges count as restarts and that a steady level of either polarity still times out. Each of the three select codes is measured against its own interval, and code 11 is run well past the longest interval to show the watchdog is off. A single late kick measures the synchronizer latency to the exact edge. A supply drop with `cfg_sel` changed but not written shows the select code persists. A seeded random phase then mixes kick toggles, supply dips and configuration writes, and compares the reset output every cycle against a cycle model built from the requirements.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        WD_SHORT = 2'b00,
        WD_MID   = 2'b01,
        WD_LONG  = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/kick_edge_det.sv
module kick_edge_det (
    input  logic clk,
    input  logic arst_n,
    input  logic pin_i,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = pin_i;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sy_q <= '0;
        else         sy_q <= sy_d;
    end

    assign fall_o = sy_q.s3 & ~sy_q.s2;

    // R3
    fall_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/wd_counter.sv
module wd_counter #(
    parameter int unsigned TO_SHORT = 50_000_000,
    parameter int unsigned TO_MID   = 150_000_000,
    parameter int unsigned TO_LONG  = 350_000_000
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             hold_i,
    input  sup_pkg::wd_sel_e sel_i,
    input  logic             kick_i,
    output logic             fire_o
);
    localparam int unsigned MAXTO = sup_pkg::max3(TO_SHORT, TO_MID, TO_LONG);
    localparam int unsigned CW    = $clog2(MAXTO + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last_val;
    logic          enabled;
    logic          expired;

    always_comb begin
        unique case (sel_i)
            sup_pkg::WD_SHORT: last_val = CW'(TO_SHORT - 1);
            sup_pkg::WD_MID:   last_val = CW'(TO_MID - 1);
            sup_pkg::WD_LONG:  last_val = CW'(TO_LONG - 1);
            default:           last_val = CW'(MAXTO - 1);
        endcase
        enabled = (sel_i != sup_pkg::WD_OFF);
        expired = enabled && (cnt_q >= last_val);
        cnt_d   = cnt_q;
        if (hold_i || kick_i || !enabled || expired) cnt_d = '0;
        else                                          cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign fire_o = expired && !hold_i && !kick_i;

    // R3
    kick_clears_chk: assert property (@(posedge clk) disable iff (!arst_n)
        kick_i |=> (cnt_q == '0));
    // R7
    fire_restart_chk: assert property (@(posedge clk) disable iff (!arst_n)
        fire_o |=> (cnt_q == '0));
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!arst_n)
        cnt_q <= CW'(MAXTO - 1));

endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
    parameter int unsigned STRETCH_CYC = 62_500_000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic trig_i,
    output logic active_o
);
    localparam int unsigned SW = $clog2(STRETCH_CYC + 1);

    typedef struct packed {
        logic          active;
        logic [SW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (st_q.cnt == SW'(STRETCH_CYC - 1)) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '{active: 1'b1, cnt: '0};
        else         st_q <= st_d;
    end

    assign active_o = st_q.active;

    // R7
    trig_holds_chk: assert property (@(posedge clk) disable iff (!arst_n)
        trig_i |=> st_q.active);
    // R2
    release_len_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(st_q.active) |-> ($past(st_q.cnt) == SW'(STRETCH_CYC - 1)));
    // R2
    stretch_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q.active && !trig_i && st_q.cnt != SW'(STRETCH_CYC - 1))
        |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
    parameter int unsigned STRETCH_CYC  = 62_500_000,
    parameter int unsigned WD_CYC_SHORT = 50_000_000,
    parameter int unsigned WD_CYC_MID   = 150_000_000,
    parameter int unsigned WD_CYC_LONG  = 350_000_000
) (
    input  logic       clk,
    input  logic       supply_ok,
    input  logic       wd_kick_cs,
    input  logic       cfg_we,
    input  logic [1:0] cfg_sel,
    output logic       rst_out_n
);
    logic [1:0] sel_d, sel_q;
    logic       kick_fall;
    logic       wd_fire;
    logic       hold;

    // Selection register: no reset, only the write strobe changes it.
    always_comb begin
        sel_d = sel_q;
        if (cfg_we) sel_d = cfg_sel;
    end

    always_ff @(posedge clk) begin
        sel_q <= sel_d;
    end

    kick_edge_det u_edge (
        .clk    (clk),
        .arst_n (supply_ok),
        .pin_i  (wd_kick_cs),
        .fall_o (kick_fall)
    );

    wd_counter #(
        .TO_SHORT (WD_CYC_SHORT),
        .TO_MID   (WD_CYC_MID),
        .TO_LONG  (WD_CYC_LONG)
    ) u_wd (
        .clk    (clk),
        .arst_n (supply_ok),
        .hold_i (hold),
        .sel_i  (sup_pkg::wd_sel_e'(sel_q)),
        .kick_i (kick_fall),
        .fire_o (wd_fire)
    );

    rst_stretch #(
        .STRETCH_CYC (STRETCH_CYC)
    ) u_st (
        .clk      (clk),
        .arst_n   (supply_ok),
        .trig_i   (wd_fire),
        .active_o (hold)
    );

    assign rst_out_n = supply_ok & ~hold;

    // R8
    cfg_keep_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        !cfg_we |=> $stable(sel_q));
    // R6
    wd_off_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        (sel_q == 2'b11) |-> !wd_fire);

endmodule

// File: tb/tb_reset_supervisor.sv
module tb_reset_supervisor;
    localparam int S  = 24;
    localparam int T0 = 16;
    localparam int T1 = 40;
    localparam int T2 = 72;

    logic       clk = 1'b0;
    logic       supply_ok = 1'b0;
    logic       kick = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'b00;
    logic       rst_out_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    reset_supervisor #(
        .STRETCH_CYC (S), .WD_CYC_SHORT (T0), .WD_CYC_MID (T1), .WD_CYC_LONG (T2)
    ) dut (
        .clk (clk), .supply_ok (supply_ok), .wd_kick_cs (kick),
        .cfg_we (cfg_we), .cfg_sel (cfg_sel), .rst_out_n (rst_out_n)
    );

    // Cycle model written from the requirements.
    logic [1:0] m_sel = 2'b00;
    bit m_k1, m_k2, m_k3, m_act;
    int m_s, m_w;

    function automatic int interval(input logic [1:0] sel);
        case (sel)
            2'b00:   return T0;
            2'b01:   return T1;
            default: return T2;
        endcase
    endfunction

    always @(posedge clk) begin
        bit fall, en, fire;
        if (!supply_ok) begin
            m_k1 = 0; m_k2 = 0; m_k3 = 0; m_act = 1; m_s = 0; m_w = 0;
        end else begin
            fall = m_k3 && !m_k2;
            en   = (m_sel != 2'b11);
            fire = en && !m_act && !fall && (m_w >= interval(m_sel) - 1);
            if (m_act || fall || !en || m_w >= interval(m_sel) - 1) m_w = 0;
            else m_w = m_w + 1;
            if (fire) begin m_act = 1; m_s = 0; end
            else if (m_act) begin
                if (m_s == S - 1) begin m_act = 0; m_s = 0; end
                else m_s = m_s + 1;
            end
            m_k3 = m_k2; m_k2 = m_k1; m_k1 = kick;
        end
        if (cfg_we) m_sel = cfg_sel;
    end

    function automatic bit expected_rst_n();
        return supply_ok && !m_act;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input string req);
        @(posedge clk);
        @(negedge clk);
        check(req, rst_out_n, expected_rst_n());
    endtask

    task automatic cycles(input int n, input string req);
        for (int i = 0; i < n; i++) step(req);
    endtask

    // Counts edges until rst_out_n reaches lvl.
    task automatic until_level(input bit lvl, input int limit, output int n);
        n = 0;
        while (rst_out_n != lvl && n < limit) begin
            step("model");
            n++;
        end
    endtask

    task automatic write_cfg(input logic [1:0] v);
        cfg_sel = v; cfg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        @(negedge clk);
        write_cfg(2'b00);
        cycles(3, "R1");
        // R1: held while supply low
        check("R1", rst_out_n, 0);

        // R2: stretch length after supply good
        supply_ok = 1'b1;
        until_level(1'b1, 1000, n);
        check("R2", n, S);

        // R4 R5: kick steady high, short interval
        until_level(1'b0, 1000, n);
        check("R4 high short", n, T0);
        // R7: watchdog reset stretched
        until_level(1'b1, 1000, n);
        check("R7", n, S);

        // R4 R5: kick steady low, mid interval (written during reset)
        kick = 1'b0;
        until_level(1'b0, 1000, n);
        write_cfg(2'b01);
        until_level(1'b1, 1000, n);
        until_level(1'b0, 1000, n);
        check("R4 low mid", n, T1);

        write_cfg(2'b10);
        until_level(1'b1, 1000, n);
        until_level(1'b0, 1000, n);
        check("R5 long", n, T2);

        // R6: disabled
        write_cfg(2'b11);
        until_level(1'b1, 1000, n);
        cycles(3 * T2, "R6");
        check("R6", rst_out_n, 1);

        // R3: late kick restarts, latency two edges
        kick = 1'b1;
        write_cfg(2'b00);
        until_level(1'b0, 1000, n);
        until_level(1'b1, 1000, n);
        cycles(5, "R3");
        kick = 1'b0;
        until_level(1'b0, 1000, n);
        check("R3", n, T0 + 3);

        // R8: select survives supply loss, ignored without write
        write_cfg(2'b10);
        supply_ok = 1'b0;
        cfg_sel = 2'b00;
        cycles(4, "R1");
        check("R1 drop", rst_out_n, 0);
        supply_ok = 1'b1;
        until_level(1'b1, 1000, n);
        check("R2 again", n, S);
        until_level(1'b0, 1000, n);
        check("R8", n, T2);

        // R9: kick lands on the expiry edge -> no reset
        kick = 1'b1;
        write_cfg(2'b00);
        until_level(1'b1, 1000, n);
        cycles(T0 - 3, "R9");
        kick = 1'b0;
        cycles(6, "R9");
        check("R9", rst_out_n, 1);

        // Random phase against the model (R2 R3 R4 R7 R8)
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 100 < 8) kick = ~kick;
            if (supply_ok && ($urandom % 400 == 0)) supply_ok = 1'b0;
            else if (!supply_ok && ($urandom % 20 == 0)) supply_ok = 1'b1;
            cfg_sel = 2'($urandom % 4);
            cfg_we = ($urandom % 150 == 0);
            step("R4 random");
        end
        cfg_we = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule